// File: doc/BRIEF.md
# Receive Code-Group Decoder

This block sits on the receive side of one lane of a multi-gigabit serial link. After the lane is deserialized and aligned, each 10-bit code group is handed to it. The block then places the result on a 10-bit parallel bus for the host. Bit 0 of the incoming word is the first bit that came off the wire and bit 9 is the last. A qualifying strobe marks the cycles that carry a code group. The result appears on the bus one clock later, together with its own valid strobe.

A mode input selects how the block works. With the mode low the block is a plain pass-through: the code group reaches the bus unchanged. With the mode high the code group is decoded as 8b/10b, checked against the running disparity, and reported as a byte with two flags. Bus bit 8 marks a control character and bus bit 9 marks a receive error. Any fault (a code group that does not exist, a code group of the wrong disparity, or a control code outside the standard set) drives both flags high and forces the byte to all ones.

Top module: `rx_cg_decoder`

## Requirements
- R1: With `decode_en` low, an accepted code group appears on `rx_bus` unchanged, so `rx_bus[0]` is the first serial bit and `rx_bus[9]` the last.
- R2: With `decode_en` high, a valid data code group gives its byte on `rx_bus[7:0]`, with `rx_bus[8]` and `rx_bus[9]` low. The byte layout is {y[2:0], x[4:0]} for D.x.y.
- R3: With `decode_en` high, the twelve standard control characters are reported with `rx_bus[8]` high, `rx_bus[9]` low, and the control value on `rx_bus[7:0]`. The twelve are K.28.0 to K.28.7, K.23.7, K.27.7, K.29.7 and K.30.7, each with value {y, x}, for example K.28.5 = 0xBC.
- R4: With `decode_en` high, a code group that matches no data or control code gives `rx_bus` = 0x3FF: both flags high and the byte forced to 0xFF.
- R5: With `decode_en` high, a code group that is valid only under the opposite running disparity is reported as an error, with `rx_bus` = 0x3FF.
- R6: Running disparity is negative after reset. After every accepted code group, in either mode and including erroneous groups, it becomes positive if the group has more than five ones, negative if it has fewer than five, and stays the same if it has exactly five.
- R7: A code group that decodes only as a control character outside the twelve of R3 is reported as an error (0x3FF).
- R8: `out_valid` is high exactly one cycle after each cycle with `cg_valid` high. While `cg_valid` is low, `rx_bus` holds its value.
- R9: During and right after reset, `out_valid` is low and `rx_bus` is zero.
- R10: The alternate x.7 sub-block is accepted exactly where the encoding rules require it: for D.17/18/20 after negative disparity and for D.11/13/14 after positive disparity. The primary form in those places is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decode_en | input | 1 | 1 = decode 8b/10b, 0 = raw pass-through |
| cg_valid | input | 1 | Qualifies `cg_in` in this cycle |
| cg_in | input | 10 | Code group, bit 0 received first |
| out_valid | output | 1 | `rx_bus` carries a new result |
| rx_bus | output | 10 | Raw code group, or {error, K flag, byte} |

## Verification
The decoder receives a sequence that starts from the reset disparity and moves it both ways. The sequence includes both polarities of K.28.5 and neutral, unbalanced and .3 data groups. Sending the same K.28.5 pattern at both disparities separates a disparity fault from a good decode. An all-zero word and a primary x.7 used where the alternate is required separate an invalid-code fault from a valid decode. A nonstandard K.1.7 pattern shows that the control set is limited to twelve entries. Raw-mode words are chosen so that a reversed or altered bit order would show. A reset that follows a group which left the disparity positive shows that reset returns it to negative.

// File: rtl/rx_cg_decoder.sv
module rx_cg_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       decode_en,
  input  logic       cg_valid,
  input  logic [9:0] cg_in,
  output logic       out_valid,
  output logic [9:0] rx_bus
);

  // 6-bit sub-block, negative-disparity form, written a..i (MSB = a)
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011;  3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101;  3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101;  3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110;  default: four_neg = 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] four_k28(input logic [2:0] y);
    case (y)
      3'd0: four_k28 = 4'b0100;  3'd1: four_k28 = 4'b1001;
      3'd2: four_k28 = 4'b0101;  3'd3: four_k28 = 4'b0011;
      3'd4: four_k28 = 4'b0010;  3'd5: four_k28 = 4'b1010;
      3'd6: four_k28 = 4'b0110;  default: four_k28 = 4'b1000;
    endcase
  endfunction

  // full code group, a..j with a in bit 9
  function automatic logic [9:0] encode(input logic k, input logic [7:0] b, input logic rdp);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s;
    logic [3:0] f;
    logic       unb, rd6, alt;
    x = b[4:0];
    y = b[7:5];
    s = (k && x == 5'd28) ? 6'b001111 : six_neg(x);
    unb = ($countones(s) != 3);
    if (k) begin
      f = (x == 5'd28) ? four_k28(y) : 4'b1000;
      encode = rdp ? ~{s, f} : {s, f};
    end else begin
      if (rdp && (unb || x == 5'd7)) s = ~s;
      rd6 = rdp ^ unb;
      alt = (y == 3'd7) &&
            ((!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
             ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      f = alt ? 4'b0111 : four_neg(y);
      if (rd6 && ($countones(f) != 2 || y == 3'd3)) f = ~f;
      encode = {s, f};
    end
  endfunction

  function automatic logic is_ctrl(input logic [7:0] v);
    is_ctrl = (v[4:0] == 5'd28) ||
              (v[7:5] == 3'd7 && (v[4:0] == 5'd23 || v[4:0] == 5'd27 ||
                                  v[4:0] == 5'd29 || v[4:0] == 5'd30));
  endfunction

  logic       rd_pos;
  logic [9:0] cw;
  logic [7:0] dec_byte;
  logic       hit, kflag;
  logic [3:0] ones;

  always_comb
    for (int i = 0; i < 10; i++) cw[9-i] = cg_in[i];

  assign ones = 4'($countones(cg_in));

  always_comb begin
    hit = 1'b0;
    kflag = 1'b0;
    dec_byte = 8'hFF;
    for (int i = 0; i < 256; i++)
      if (encode(1'b0, 8'(i), rd_pos) == cw) begin
        hit = 1'b1;
        dec_byte = 8'(i);
      end
    for (int i = 0; i < 256; i++)
      if (is_ctrl(8'(i)) && encode(1'b1, 8'(i), rd_pos) == cw) begin
        hit = 1'b1;
        kflag = 1'b1;
        dec_byte = 8'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pos    <= 1'b0;
      out_valid <= 1'b0;
      rx_bus    <= '0;
    end else begin
      out_valid <= cg_valid;
      if (cg_valid) begin
        if (ones > 4'd5)      rd_pos <= 1'b1;
        else if (ones < 4'd5) rd_pos <= 1'b0;
        if (!decode_en)       rx_bus <= cg_in;
        else if (!hit)        rx_bus <= 10'h3FF;
        else                  rx_bus <= {1'b0, kflag, dec_byte};
      end
    end
  end

  // R1
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && !decode_en) |=> (rx_bus == $past(cg_in)));

  // R8
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_valid |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_valid |=> (!out_valid && $stable(rx_bus)));

  // R4
  err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && decode_en) |=> (!rx_bus[9] || rx_bus[8:0] == 9'h1FF));

  // R3
  kset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_valid && decode_en) |=> (rx_bus[9] || !rx_bus[8] || is_ctrl(rx_bus[7:0])));

endmodule

// File: tb/rx_cg_decoder_test.sv
module rx_cg_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {decode_en, code group written a..j, expected rx_bus}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 10'b0011111010, 10'h1BC},
    {1'b1, 10'b1100000101, 10'h1BC},
    {1'b1, 10'b1001110100, 10'h000},
    {1'b1, 10'b1010101010, 10'h0B5},
    {1'b1, 10'b1100000101, 10'h3FF},
    {1'b1, 10'b0000000000, 10'h3FF},
    {1'b1, 10'b1100011011, 10'h003},
    {1'b1, 10'b0101010011, 10'h06A},
    {1'b1, 10'b1101001000, 10'h0EB},
    {1'b1, 10'b1000110111, 10'h0F1},
    {1'b1, 10'b1101000001, 10'h3FF},
    {1'b1, 10'b0111011000, 10'h3FF},
    {1'b1, 10'b1110101000, 10'h1F7},
    {1'b0, 10'b1010101010, 10'h155},
    {1'b0, 10'b0011111010, 10'h17C},
    {1'b1, 10'b0011111010, 10'h3FF},
    {1'b1, 10'b1100000101, 10'h1BC},
    {1'b1, 10'b1110001001, 10'h027}
  };
  localparam string TAG [NV] = '{
    "R3", "R3", "R2", "R2", "R5", "R4", "R2", "R2", "R10",
    "R10", "R10", "R7", "R3", "R1", "R1", "R6", "R6", "R2"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic decode_en = 1'b0;
  logic cg_valid = 1'b0;
  logic [9:0] cg_in = '0;
  logic out_valid;
  logic [9:0] rx_bus;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  rx_cg_decoder uut (
    .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .cg_valid(cg_valid),
    .cg_in(cg_in), .out_valid(out_valid), .rx_bus(rx_bus)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [9:0] wire_order(input logic [9:0] aj);
    for (int i = 0; i < 10; i++) wire_order[i] = aj[9-i];
  endfunction

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%03h expected 0x%03h", tag, got, exp);
    end
  endtask

  task automatic send(input logic mode, input logic [9:0] aj);
    @(negedge clk);
    decode_en = mode;
    cg_in = wire_order(aj);
    cg_valid = 1'b1;
    @(negedge clk);
    cg_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {9'd0, out_valid}, 10'd0);
    check("R9", rx_bus, 10'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20], VEC[i][19:10]);
      check(TAG[i], {9'd0, out_valid}, 10'd1);
      check(TAG[i], rx_bus, VEC[i][9:0]);
    end

    // R8: no strobe, output holds and valid drops
    @(negedge clk);
    check("R8", {9'd0, out_valid}, 10'd0);
    check("R8", rx_bus, 10'h027);

    // R6: push disparity positive, then reset must bring it back negative
    send(1'b1, 10'b0011111010);
    check("R6", rx_bus, 10'h1BC);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", {9'd0, out_valid}, 10'd0);
    check("R9", rx_bus, 10'd0);
    rst_n = 1'b1;
    send(1'b1, 10'b1100000101);
    check("R6", rx_bus, 10'h3FF);
    send(1'b1, 10'b0011111010);
    check("R6", rx_bus, 10'h1BC);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule